// File: doc/BRIEF.md
# Parallel-Access Shift Register with JK Serial Entry

This block is a register of `WIDTH` flip-flops, four by default, with two synchronous modes picked by an active-low select. In shift mode every rising clock edge moves each stage one place toward the most significant stage. The new value of stage 0 comes from a J input and an active-low K input, so the first stage can be set, cleared, toggled or held. In load mode every rising clock edge copies a parallel data bus into the stages, and the J and K inputs have no effect.

Every stage has a true output. The most significant stage also has a complemented output. An active-low master reset clears every stage at once, with no clock edge needed. When J and K are tied together, the serial entry acts as a plain D input. A left shift is made outside the block: hold load mode and feed each stage's output back to the data input of the stage below it.

Top module: `pshift_jk`

## Requirements
- R1: While `mrst_n` is 0, `q_out` is all zeros and `q_last_n` is 1 at once, with no clock edge needed, whatever the other inputs are.
- R2: With `load_n`=1 at a rising edge, each stage i (i ≥ 1) takes the value stage i-1 held before that edge.
- R3: With `load_n`=1 at a rising edge, stage 0 is updated from the pair {`j_in`,`k_n`} as follows. 11 sets it to 1. 00 clears it to 0. 10 inverts its previous value. 01 keeps its previous value.
- R4: With `j_in` and `k_n` driven by the same bit b in shift mode, stage 0 takes b.
- R5: With `load_n`=0 at a rising edge, bit i of `par_in` is loaded into stage i. `j_in` and `k_n` have no effect on the result.
- R6: `q_last_n` always equals the inverse of `q_out[WIDTH-1]`, including during reset.
- R7: With reset inactive, `q_out` changes only at a rising clock edge. Input changes between edges leave it unchanged.
- R8: In load mode, with `par_in[i]` wired to `q_out[i+1]` and a fill bit on `par_in[WIDTH-1]`, each edge shifts the register toward stage 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; transfers take place on the rising edge |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| load_n | input | 1 | Mode select: 0 loads in parallel, 1 shifts |
| j_in | input | 1 | J serial input to stage 0 |
| k_n | input | 1 | K serial input to stage 0, active low |
| par_in | input | WIDTH | Parallel data inputs, bit i feeds stage i |
| q_out | output | WIDTH | True outputs of all stages |
| q_last_n | output | 1 | Inverse of the most significant stage |

## Verification
The asynchronous master reset and a synchronous shift or load can fall in the same clock period. The bench provokes this by driving a shift or load command and then pulling reset low in the middle of that period, so that reset is still low at the next rising edge. The outputs are judged twice. Right after reset falls, before any edge, the bench checks the cleared value. After reset is released, the bench checks that the clock edge during reset made no transfer and that later edges resume from zero.

// File: rtl/pshift_pkg.sv
// Shared types for the parallel-access shift register.
// Assumes the JK command is formed as {j, k_n}.
package pshift_pkg;

    // First-stage command, encoded as {j_in, k_n}
    typedef enum logic [1:0] {
        JK_CLEAR  = 2'b00,
        JK_HOLD   = 2'b01,
        JK_TOGGLE = 2'b10,
        JK_SET    = 2'b11
    } jk_cmd_e;

    // Next value of the first stage for a given command and previous value
    function automatic logic jk_next(input jk_cmd_e cmd, input logic prev);
        logic nxt;
        case (cmd)
            JK_CLEAR:  nxt = 1'b0;
            JK_HOLD:   nxt = prev;
            JK_TOGGLE: nxt = ~prev;
            default:   nxt = 1'b1;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/pshift_head.sv
// Serial entry decoder for stage 0. It turns the J and active-low K inputs
// into the value that stage 0 takes in shift mode.
// Assumes: purely combinational, driven by the current value of stage 0.
module pshift_head
    import pshift_pkg::*;
(
    input  logic j_in,
    input  logic k_n,
    input  logic prev,
    output logic head_d
);

    jk_cmd_e cmd;

    // Decode the JK pair and pick the next value of stage 0
    always_comb begin
        cmd    = jk_cmd_e'({j_in, k_n});
        head_d = jk_next(cmd, prev);
    end

endmodule

// File: rtl/pshift_cell.sv
// One register stage. On each rising edge it captures either its shift
// source or its parallel input. It is cleared at once by the master reset.
// Assumes: load_n is stable around the clock edge.
module pshift_cell (
    input  logic clk,
    input  logic mrst_n,
    input  logic load_n,
    input  logic shift_d,
    input  logic par_d,
    output logic q
);

    logic d_sel;

    // Choose the shift or load source
    always_comb d_sel = load_n ? shift_d : par_d;

    // Storage with asynchronous clear
    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) q <= 1'b0;
        else         q <= d_sel;
    end

endmodule

// File: rtl/pshift_jk.sv
// Parallel-access right-shift register with JK serial entry and an inverted
// output from the last stage. Stage 0 is fed by the JK decoder and stage i
// by stage i-1. Assumes WIDTH >= 2.
module pshift_jk #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             load_n,
    input  logic             j_in,
    input  logic             k_n,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q_out,
    output logic             q_last_n
);

    localparam int MSB = WIDTH - 1;

    logic             head_d;
    logic [WIDTH-1:0] shift_src;

    pshift_head u_head (
        .j_in   (j_in),
        .k_n    (k_n),
        .prev   (q_out[0]),
        .head_d (head_d)
    );

    // Build the stage chain: stage 0 from the head, the others from their neighbour
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign shift_src[i] = head_d;
        end else begin : g_rest
            assign shift_src[i] = q_out[i-1];
        end
        pshift_cell u_cell (
            .clk     (clk),
            .mrst_n  (mrst_n),
            .load_n  (load_n),
            .shift_d (shift_src[i]),
            .par_d   (par_in[i]),
            .q       (q_out[i])
        );
    end

    // Complemented last-stage output
    assign q_last_n = ~q_out[MSB];

    // Outputs are cleared while reset is low
    assert_reset_R1: assert property (@(posedge clk)
        !mrst_n |-> (q_out == '0 && q_last_n));

    // Upper stages follow their lower neighbour in shift mode
    assert_shift_R2: assert property (@(posedge clk) disable iff (!mrst_n)
        load_n |=> q_out[MSB:1] == $past(q_out[MSB-1:0]));

    assert_set_R3: assert property (@(posedge clk) disable iff (!mrst_n)
        (load_n && j_in && k_n) |=> q_out[0]);

    assert_clear_R3: assert property (@(posedge clk) disable iff (!mrst_n)
        (load_n && !j_in && !k_n) |=> !q_out[0]);

    assert_toggle_R3: assert property (@(posedge clk) disable iff (!mrst_n)
        (load_n && j_in && !k_n) |=> q_out[0] != $past(q_out[0]));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!mrst_n)
        (load_n && !j_in && k_n) |=> $stable(q_out[0]));

    // Parallel load copies the bus
    assert_load_R5: assert property (@(posedge clk) disable iff (!mrst_n)
        !load_n |=> q_out == $past(par_in));

    // Inverted output tracks the last stage
    assert_inverse_R6: assert property (@(negedge clk) disable iff (!mrst_n)
        q_last_n == !q_out[MSB]);

endmodule

// File: tb/pshift_jk_test.sv
`timescale 1ns/1ps
module pshift_jk_test;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         mrst_n = 1'b0;
    logic         load_n = 1'b1;
    logic         j_in = 1'b0;
    logic         k_n = 1'b1;
    logic [W-1:0] par_reg = '0;
    logic         lshift = 1'b0;
    logic         fill = 1'b0;
    logic [W-1:0] par_in;
    logic [W-1:0] q_out;
    logic         q_last_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [W-1:0] exp_q = '0;

    always #2.5 clk = ~clk;

    // External feedback for a left shift (R8)
    assign par_in = lshift ? {fill, q_out[W-1:1]} : par_reg;

    pshift_jk #(.WIDTH(W)) uut (
        .clk(clk), .mrst_n(mrst_n), .load_n(load_n), .j_in(j_in),
        .k_n(k_n), .par_in(par_in), .q_out(q_out), .q_last_n(q_last_n)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_out(input string tag);
        chk(tag, q_out, exp_q);
        chk({tag, " R6"}, {{(W-1){1'b0}}, q_last_n}, {{(W-1){1'b0}}, ~exp_q[W-1]});
    endtask

    // Model of one edge, computed from the requirements
    function automatic logic [W-1:0] model(input logic [W-1:0] cur, input logic ld_n,
                                           input logic j, input logic kn, input logic [W-1:0] d);
        logic h;
        if (!ld_n) return d;
        if (j && kn)        h = 1'b1;
        else if (!j && !kn) h = 1'b0;
        else if (j)         h = ~cur[0];
        else                h = cur[0];
        return {cur[W-2:0], h};
    endfunction

    // One clock: drive at negedge, check at the next negedge
    task automatic step(input string tag, input logic ld_n, input logic j,
                        input logic kn, input logic [W-1:0] d);
        load_n = ld_n; j_in = j; k_n = kn; par_reg = d;
        #0.5;
        chk({tag, " R7 before edge"}, q_out, exp_q);
        exp_q = model(exp_q, ld_n, j, kn, d);
        @(negedge clk);
        chk_out(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Reset state
        #1;
        exp_q = '0;
        chk_out("R1 reset at start");
        @(negedge clk); @(negedge clk);
        chk_out("R1 reset held");
        mrst_n = 1'b1;
        @(negedge clk);
        chk_out("R1 after release");

        // R3 and R2: every JK command from every prior state
        for (int s = 0; s < (1 << W); s++) begin
            for (int c = 0; c < 4; c++) begin
                step("R5 preload", 1'b0, 1'b0, 1'b1, W'(s));
                step("R2 R3 jk shift", 1'b1, c[1], c[0], W'(~s));
            end
        end

        // R5: load every value under every JK pair
        for (int d = 0; d < (1 << W); d++)
            for (int c = 0; c < 4; c++)
                step("R5 load ignores jk", 1'b0, c[1], c[0], W'(d));

        // R4: tied J/K acts as D input
        for (int n = 0; n < 24; n++) begin
            logic b;
            b = n[0] ^ n[2] ^ n[4];
            step("R4 d entry", 1'b1, b, b, '0);
        end

        // R8: left shift through external feedback
        step("R5 preload", 1'b0, 1'b0, 1'b0, 4'b1011);
        lshift = 1'b1;
        for (int n = 0; n < 8; n++) begin
            fill = n[0];
            load_n = 1'b0;
            exp_q = {fill, exp_q[W-1:1]};
            @(negedge clk);
            chk_out("R8 left shift");
        end
        lshift = 1'b0;

        // Random sequences with mid-stream asynchronous resets (R1 with R2/R5)
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] r;
            r = 8'($urandom);
            if (n % 97 == 50) begin
                load_n = r[0]; j_in = r[1]; k_n = r[2]; par_reg = r[7:4];
                #1 mrst_n = 1'b0;
                #0.1;
                exp_q = '0;
                chk_out("R1 async clear mid-cycle");
                @(negedge clk);
                chk_out("R1 edge during reset");
                mrst_n = 1'b1;
                #0.5;
                chk_out("R1 after release");
            end else begin
                step("R2 R3 R5 random", r[0] | r[3], r[1], r[2], r[7:4]);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule